// File: doc/BRIEF.md
# Microsecond Limit Timer with Acknowledge-on-Read

This block is a free-running counter with a programmable limit, meant to produce a periodic interrupt tick. The system instance of the block serves the priority-10 system tick, and each processor has its own instance for the priority-14 profiling tick. The counter moves forward once per pulse of a 1 MHz enable. When it reaches the programmed limit it restarts and raises an interrupt. That interrupt stays pending until software reads the acknowledging limit address.

Count and limit values sit left-justified in the 32-bit word, in bits 31:10, and the low ten bits are always zero. A second limit address returns the same value but has no side effect, so software can look at the limit without losing a pending tick. A run control pauses the counter. It exists when `HAS_RUN_CTRL` is 1, which is the setting for the per-processor instances. Register access uses plain single-cycle strobes. Read data is combinational and is valid in the cycle `rd_en` is high. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `lct_timer`

## Requirements
- R1: After reset, the count address reads 0x00000400 (count 1, flag clear), both limit addresses read 0, the run address reads 1, and `irq` is low.
- R2: On a cycle with `usec_en` high, the run bit set, no limit write and no limit match, the count field (bits 30:10 of the count address) increases by one. With `usec_en` low it holds. Bits 9:0 of every read are zero.
- R3: On a cycle with `usec_en` high, the run bit set, a nonzero limit and a count equal to the limit, the count becomes 1 and `irq` goes high in the next cycle. The period is therefore the limit value in enable pulses.
- R4: A read with `reg_sel`=1 (acknowledging limit) returns the limit in bits 31:10 and clears `irq` from the next cycle on.
- R5: A read with `reg_sel`=2 (peek limit) returns the same value as `reg_sel`=1 and leaves `irq` unchanged. Reads of the count (`reg_sel`=0) and run (`reg_sel`=3) addresses also leave `irq` unchanged.
- R6: If a limit match happens in the same cycle as an acknowledging read, `irq` stays high.
- R7: While the limit is 0, `irq` never rises and the counter keeps counting.
- R8: A write with `reg_sel`=1 loads bits 31:10 of `wr_data` as the limit, sets the count to 1 and clears `irq`. It takes priority over a count enable in the same cycle.
- R9: Bit 31 of the count address read equals `irq`.
- R10: A write with `reg_sel`=3 sets the run bit from `wr_data[0]`, and the bit reads back in bit 0. While the run bit is 0 the count holds and no match is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usec_en | input | 1 | 1 MHz count enable pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects apply at the clock edge) |
| reg_sel | input | 2 | 0 count, 1 limit with acknowledge, 2 limit peek, 3 run control |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_sel` |
| irq | output | 1 | Pending tick interrupt |

## Verification
The tick path is driven in four ways. Plain enable pulses below the limit show that the counter advances only on the enable. A run to the limit of 3 shows that the wrap lands on 1 and the flag rises in the same step. A limit of 0 shows that the counter runs on without any interrupt. A paused run shows that the run bit gates both the count and the match. The read paths are then exercised against a pending flag: the peek address, count reads and run reads must leave it set, the acknowledging read must drop it, and an acknowledging read that coincides with a match must keep it set. A limit write that lands on an enable pulse separates the reload priority from the ordinary increment.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int DATA_W    = 32;
  localparam int FIELD_LSB = 10;
  localparam int CNT_W     = DATA_W - FIELD_LSB;

  typedef enum logic [1:0] {
    SEL_COUNT      = 2'd0,
    SEL_LIMIT_ACK  = 2'd1,
    SEL_LIMIT_PEEK = 2'd2,
    SEL_RUN        = 2'd3
  } sel_e;
endpackage

// File: rtl/lct_counter.sv
module lct_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign hit = adv && !load && (limit != '0) && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= ONE;
      limit <= '0;
    end else if (load) begin
      count <= ONE;
      limit <= load_val;
    end else if (hit) begin
      count <= ONE;
    end else if (adv) begin
      count <= count + ONE;
    end
  end

  // R3
  wrap_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count == ONE));

  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == ONE) && (limit == $past(load_val)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(count));
endmodule

// File: rtl/lct_flag.sv
module lct_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  input  logic load,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (hit)    flag <= 1'b1;
    else if (load)   flag <= 1'b0;
    else if (ack)    flag <= 1'b0;
  end

  // R6
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !flag);

  // R8
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hit) |=> !flag);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ack && !load) |=> $stable(flag));
endmodule

// File: rtl/lct_rdmux.sv
module lct_rdmux
  import lct_pkg::*;
(
  input  sel_e              sel,
  input  logic [CNT_W-2:0]  count_low,
  input  logic [CNT_W-1:0]  limit,
  input  logic              flag,
  input  logic              run,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    unique case (sel)
      SEL_COUNT:      data = {flag, count_low, {FIELD_LSB{1'b0}}};
      SEL_LIMIT_ACK,
      SEL_LIMIT_PEEK: data = {limit, {FIELD_LSB{1'b0}}};
      SEL_RUN:        data = {{(DATA_W-1){1'b0}}, run};
      default:        data = '0;
    endcase
  end
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter bit HAS_RUN_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usec_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  sel_e             sel;
  logic             run;
  logic             adv, load, ack, hit;
  logic [CNT_W-1:0] count_q, limit_q;

  assign sel  = sel_e'(reg_sel);
  assign load = wr_en && (sel == SEL_LIMIT_ACK);
  assign ack  = rd_en && (sel == SEL_LIMIT_ACK);
  assign adv  = usec_en && run;

  wire unused_low = &{1'b0, wr_data[FIELD_LSB-1:1]};

  generate
    if (HAS_RUN_CTRL) begin : g_run
      logic run_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                           run_q <= 1'b1;
        else if (wr_en && sel == SEL_RUN)     run_q <= wr_data[0];
      end
      assign run = run_q;
    end else begin : g_norun
      wire unused_run = wr_data[0];
      assign run = 1'b1;
    end
  endgenerate

  lct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (load),
    .load_val (wr_data[DATA_W-1:FIELD_LSB]),
    .count    (count_q),
    .limit    (limit_q),
    .hit      (hit)
  );

  lct_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .ack   (ack),
    .load  (load),
    .flag  (irq)
  );

  lct_rdmux u_rdmux (
    .sel       (sel),
    .count_low (count_q[CNT_W-2:0]),
    .limit     (limit_q),
    .flag      (irq),
    .run       (run),
    .data      (rd_data)
  );

  // R7
  zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (limit_q != '0));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usec_en && run && !load && !hit) |=> (count_q == $past(count_q) + 1'b1));

  // R10
  paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count_q) && !$rose(irq));
endmodule

// File: tb/lct_timer_tb.sv
`timescale 1ns/1ps
module lct_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        usec_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lct_timer u_dut (
    .clk(clk), .rst_n(rst_n), .usec_en(usec_en), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic te, input logic we, input logic re,
                     input logic [1:0] sel, input logic [31:0] wd,
                     output logic [31:0] rdv);
    @(negedge clk);
    usec_en = te; wr_en = we; rd_en = re; reg_sel = sel; wr_data = wd;
    #1 rdv = rd_data;
    @(posedge clk);
    #1;
    usec_en = 0; wr_en = 0; rd_en = 0; wr_data = '0;
  endtask

  task automatic ticks(int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, d);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    cyc(0, 0, 1, sel, 0, d);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] v);
    logic [31:0] d;
    cyc(0, 1, 0, sel, v, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    rd(0, d); check("R1 count", d, 32'h400);
    rd(2, d); check("R1 limit", d, 0);
    rd(3, d); check("R1 run", d, 1);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(1, 32'd9 << 10);
    ticks(2);
    rd(0, d); check("R2 count after 2", d, 32'hC00);
    rd(0, d); check("R2 hold without enable", d, 32'hC00);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(1, 32'd3 << 10);
    ticks(2);
    rd(0, d); check("R3 at limit no irq", d, 32'hC00);
    ticks(1);
    check("R3 irq raised", {31'b0, irq}, 1);
    rd(0, d); check("R9 count bit31 with wrap", d, 32'h8000_0400);
  endtask

  task automatic t_peek;
    logic [31:0] d;
    rd(2, d); check("R5 peek value", d, 32'hC00);
    check("R5 irq after peek", {31'b0, irq}, 1);
    rd(3, d);
    check("R5 irq after run read", {31'b0, irq}, 1);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    rd(1, d); check("R4 ack value", d, 32'hC00);
    check("R4 irq cleared", {31'b0, irq}, 0);
    rd(0, d); check("R9 count bit31 clear", d, 32'h400);
  endtask

  task automatic t_race;
    logic [31:0] d;
    ticks(2);
    cyc(1, 0, 1, 1, 0, d);
    check("R6 irq kept on same-cycle ack", {31'b0, irq}, 1);
    rd(1, d);
    check("R4 later ack clears", {31'b0, irq}, 0);
  endtask

  task automatic t_write;
    logic [31:0] d;
    ticks(1);
    cyc(1, 1, 0, 1, 32'd7 << 10, d);
    rd(0, d); check("R8 count reloaded over tick", d, 32'h400);
    rd(2, d); check("R8 new limit", d, 32'h1C00);
    ticks(6);
    check("R8 irq after 7th tick pending", {31'b0, irq}, 0);
    ticks(1);
    check("R8 irq at new period", {31'b0, irq}, 1);
    wr(1, 32'd7 << 10);
    check("R8 write clears irq", {31'b0, irq}, 0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(1, 0);
    ticks(10);
    check("R7 no irq with zero limit", {31'b0, irq}, 0);
    rd(0, d); check("R7 keeps counting", d, 32'h2C00);
  endtask

  task automatic t_run;
    logic [31:0] d;
    wr(3, 0);
    rd(3, d); check("R10 run reads 0", d, 0);
    ticks(4);
    rd(0, d); check("R10 paused count", d, 32'h2C00);
    wr(1, 32'd1 << 10);
    ticks(3);
    check("R10 no match while paused", {31'b0, irq}, 0);
    wr(3, 1);
    ticks(1);
    check("R10 match after resume", {31'b0, irq}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset(); t_count(); t_wrap(); t_peek(); t_ack();
        t_race(); t_write(); t_zero(); t_run();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule